// File: doc/BRIEF.md
# Reconfigurable Multiply-Add Slice

This slice multiplies packed operand lanes and combines the products in one of four topologies. An operand size select picks among eight narrow multipliers (9x9 by default), four medium multipliers (18x18) or one wide multiplier (36x36). For narrow and medium sizes, a combine select chooses what reaches the output. It can pass every product through on its own, add neighbouring products in pairs, add them in groups of four, or feed two 52-bit running accumulators.

Both operands of every multiplier share one signedness select. The slice is fully pipelined and accepts one beat per cycle. Operand size, combine mode and signedness are captured only at the start of a burst. This lets a host change them freely between bursts without disturbing beats that are already in flight.

Top module: `mac_slice`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `out_valid` is 0 and `res_bus` is all zeros.
- R2: A beat presented with `in_valid` high before rising edge k shows up with `out_valid` high after rising edge k+1. `out_valid` is low in every other cycle. Beats may arrive back to back.
- R3: With `size_sel`=0 and `comb_sel`=0, lane i multiplies `a_bus[9i+8:9i]` by `b_bus[9i+8:9i]` for i=0..7. Each 18-bit product is placed at `res_bus[18i+17:18i]`.
- R4: With `size_sel`=1 and `comb_sel`=0, lane i multiplies the 18-bit fields `a_bus[18i+17:18i]` and `b_bus[18i+17:18i]` for i=0..3. Each 36-bit product is placed at `res_bus[36i+35:36i]`.
- R5: With `size_sel`=2 or 3, the product of `a_bus[35:0]` and `b_bus[35:0]` is extended to all 144 bits of `res_bus`. In this size, `comb_sel`, `acc_clear` and `a_bus`/`b_bus` bits 71:36 have no effect on the result.
- R6: With `comb_sel`=2, result k is the sum of products 2k and 2k+1. Result k is placed in slot k, and each slot is twice the product width: four 36-bit slots at narrow size and two 72-bit slots at medium size.
- R7: With `comb_sel`=3, result k is the sum of products 4k to 4k+3. At narrow size this gives two 72-bit slots. At medium size it gives one 144-bit slot.
- R8: With `comb_sel`=1 at narrow or medium size, accumulator j (j=0,1) adds the sum of the products in lane half j. The lower half of the lanes feeds accumulator 0. Each accumulator is 52 bits and wraps modulo 2^52. The new accumulator value is extended into the 72-bit slot at `res_bus[72j+71:72j]`.
- R9: A beat in accumulate mode with `acc_clear`=1 loads each accumulator with that beat's half-sum instead of adding it to the old value.
- R10: `sgn_sel`=1 treats every operand as two's complement, and every product, sum and accumulator is sign-extended into its slot. `sgn_sel`=0 treats every operand as unsigned, and everything is zero-extended.
- R11: Size, combine mode and signedness are taken from the ports only for a valid beat that arrives while no beat is in flight. Such a beat uses the new settings itself. Changes to these ports during a burst have no effect on later beats of that burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand beat strobe |
| size_sel | input | 2 | Operand size: 0 narrow, 1 medium, 2/3 wide |
| comb_sel | input | 2 | Combine: 0 direct, 1 accumulate, 2 pair sums, 3 quad sums |
| sgn_sel | input | 1 | 1 signed operands, 0 unsigned |
| acc_clear | input | 1 | Load accumulators instead of adding |
| a_bus | input | 72 | Packed first operands |
| b_bus | input | 72 | Packed second operands |
| out_valid | output | 1 | Result beat strobe |
| res_bus | output | 144 | Packed results in slots |

## Verification
The hardest situation to reach is the 52-bit accumulator wrapping. The largest unsigned medium products raise it by about 2^37 per beat. The stimulus therefore streams roughly 36,000 all-ones beats back to back after one clearing beat, and it compares every intermediate value against a modulo-2^52 model.

The second hard case is a settings change in the middle of a burst. A phase with random valid gaps and settings that change every cycle separates beats that start a burst from beats that must keep the earlier settings. The settings are held, not re-read, until the pipeline has fully drained.

// File: rtl/mac_slice_pkg.sv
package mac_slice_pkg;

  typedef enum logic [1:0] {
    SZ_NARROW = 2'd0,
    SZ_MEDIUM = 2'd1,
    SZ_WIDE   = 2'd2,
    SZ_WIDE_B = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    CB_DIRECT = 2'd0,
    CB_ACCUM  = 2'd1,
    CB_PAIR   = 2'd2,
    CB_QUAD   = 2'd3
  } comb_e;

  typedef struct packed {
    size_e size;
    comb_e comb;
    logic  sgn;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{size: SZ_NARROW, comb: CB_DIRECT, sgn: 1'b0};

endpackage

// File: rtl/mac_slice_cfg.sv
module mac_slice_cfg
  import mac_slice_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic busy,
  input  cfg_t cfg_in,
  output cfg_t cfg_eff,
  output cfg_t cfg_q
);

  // Settings are captured by the first beat of a burst only.
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= CFG_RESET;
    end else if (in_valid && !busy) begin
      cfg_q <= cfg_in;
    end
  end

  // The opening beat of a burst uses the port values directly.
  assign cfg_eff = busy ? cfg_q : cfg_in;

endmodule

// File: rtl/mac_slice_mul.sv
module mac_slice_mul
  import mac_slice_pkg::*;
#(
  parameter int NW    = 9,
  parameter int NLANE = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           in_valid,
  input  cfg_t                           cfg_in,
  input  logic                           acc_clear,
  input  logic [NW*NLANE-1:0]            a_bus,
  input  logic [NW*NLANE-1:0]            b_bus,
  output logic                           v_q,
  output cfg_t                           cfg_q,
  output logic                           clr_q,
  output logic [NLANE-1:0][2*NW-1:0]     pn_q,
  output logic [NLANE/2-1:0][4*NW-1:0]   pm_q,
  output logic [8*NW-1:0]                pw_q
);

  localparam int MW    = 2 * NW;
  localparam int WW    = 4 * NW;
  localparam int MLANE = NLANE / 2;

  logic [NLANE-1:0][2*NW-1:0]  pn_d;
  logic [MLANE-1:0][2*MW-1:0]  pm_d;
  logic [2*WW-1:0]             pw_d;

  // Narrow lanes.
  for (genvar i = 0; i < NLANE; i++) begin : g_narrow
    logic signed [NW:0]     xa, xb;
    logic signed [2*NW+1:0] prod;
    assign xa   = {cfg_in.sgn & a_bus[i*NW+NW-1], a_bus[i*NW +: NW]};
    assign xb   = {cfg_in.sgn & b_bus[i*NW+NW-1], b_bus[i*NW +: NW]};
    assign prod = xa * xb;
    assign pn_d[i] = prod[2*NW-1:0];
  end

  // Medium lanes.
  for (genvar i = 0; i < MLANE; i++) begin : g_medium
    logic signed [MW:0]     xa, xb;
    logic signed [2*MW+1:0] prod;
    assign xa   = {cfg_in.sgn & a_bus[i*MW+MW-1], a_bus[i*MW +: MW]};
    assign xb   = {cfg_in.sgn & b_bus[i*MW+MW-1], b_bus[i*MW +: MW]};
    assign prod = xa * xb;
    assign pm_d[i] = prod[2*MW-1:0];
  end

  // Single wide lane on the low operand bits.
  logic signed [WW:0]     wxa, wxb;
  logic signed [2*WW+1:0] wprod;
  assign wxa   = {cfg_in.sgn & a_bus[WW-1], a_bus[WW-1:0]};
  assign wxb   = {cfg_in.sgn & b_bus[WW-1], b_bus[WW-1:0]};
  assign wprod = wxa * wxb;
  assign pw_d  = wprod[2*WW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q   <= 1'b0;
      cfg_q <= CFG_RESET;
    end else begin
      v_q <= in_valid;
      if (in_valid) cfg_q <= cfg_in;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      clr_q <= acc_clear;
      pn_q  <= pn_d;
      pm_q  <= pm_d;
      pw_q  <= pw_d;
    end
  end

endmodule

// File: rtl/mac_slice_comb.sv
module mac_slice_comb
  import mac_slice_pkg::*;
#(
  parameter int NW    = 9,
  parameter int NLANE = 8,
  parameter int ACC_W = 52
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           v_in,
  input  cfg_t                           cfg,
  input  logic                           clr,
  input  logic [NLANE-1:0][2*NW-1:0]     pn,
  input  logic [NLANE/2-1:0][4*NW-1:0]   pm,
  input  logic [8*NW-1:0]                pw,
  output logic                           out_valid,
  output logic [2*NW*NLANE-1:0]          res_bus
);

  localparam int RES_W    = 2 * NW * NLANE;
  localparam int MLANE    = NLANE / 2;
  localparam int ACC_SLOT = RES_W / 2;
  localparam logic [RES_W-1:0] ONE_R      = RES_W'(1);
  localparam logic [RES_W-1:0] ACC_LOMASK = (ONE_R << ACC_W) - ONE_R;
  localparam logic [RES_W-1:0] SLOTMASK_A = (ONE_R << ACC_SLOT) - ONE_R;

  logic [NLANE-1:0][RES_W-1:0] ext_n, ext_m, ext_sel;
  logic [RES_W-1:0]            ext_w, res_nxt, hs_full [2], acc_ext [2];
  logic [1:0][ACC_W-1:0]       acc_q, acc_nxt;
  int unsigned                 cnt;
  logic                        narrow;

  // Sum groups of grp extended products, each result masked into its slot.
  function automatic logic [RES_W-1:0] fold(input logic [NLANE-1:0][RES_W-1:0] ext,
                                             input int unsigned n, input int unsigned grp);
    logic [RES_W-1:0] r, s, m;
    int unsigned slot;
    r    = '0;
    slot = RES_W / (n / grp);
    m    = (ONE_R << slot) - ONE_R;
    for (int k = 0; k < NLANE; k++) begin
      if (k < int'(n / grp)) begin
        s = '0;
        for (int g = 0; g < NLANE; g++) begin
          if (g < int'(grp)) s = s + ext[k*int'(grp) + g];
        end
        r = r | ((s & m) << (k * int'(slot)));
      end
    end
    return r;
  endfunction

  always_comb begin
    ext_m = '0;
    for (int i = 0; i < NLANE; i++)
      ext_n[i] = {{(RES_W-2*NW){cfg.sgn & pn[i][2*NW-1]}}, pn[i]};
    for (int i = 0; i < MLANE; i++)
      ext_m[i] = {{(RES_W-4*NW){cfg.sgn & pm[i][4*NW-1]}}, pm[i]};
    ext_w = {{(RES_W-8*NW){cfg.sgn & pw[8*NW-1]}}, pw};

    narrow  = (cfg.size == SZ_NARROW);
    cnt     = narrow ? NLANE : MLANE;
    ext_sel = narrow ? ext_n : ext_m;

    for (int j = 0; j < 2; j++) begin
      hs_full[j] = '0;
      for (int m = 0; m < NLANE; m++) begin
        if (m < int'(cnt / 2)) hs_full[j] = hs_full[j] + ext_sel[j*int'(cnt/2) + m];
      end
      acc_nxt[j] = clr ? hs_full[j][ACC_W-1:0] : acc_q[j] + hs_full[j][ACC_W-1:0];
      acc_ext[j] = RES_W'(acc_nxt[j]);
      if (cfg.sgn && acc_nxt[j][ACC_W-1]) acc_ext[j] = acc_ext[j] | ~ACC_LOMASK;
    end

    if (cfg.size[1]) begin
      res_nxt = ext_w;
    end else begin
      unique case (cfg.comb)
        CB_ACCUM:  res_nxt = (acc_ext[0] & SLOTMASK_A) |
                             ((acc_ext[1] & SLOTMASK_A) << ACC_SLOT);
        CB_PAIR:   res_nxt = fold(ext_sel, cnt, 2);
        CB_QUAD:   res_nxt = fold(ext_sel, cnt, 4);
        default:   res_nxt = fold(ext_sel, cnt, 1);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      res_bus   <= '0;
      acc_q     <= '0;
    end else begin
      out_valid <= v_in;
      if (v_in) res_bus <= res_nxt;
      if (v_in && cfg.comb == CB_ACCUM && !cfg.size[1]) acc_q <= acc_nxt;
    end
  end

endmodule

// File: rtl/mac_slice.sv
module mac_slice
  import mac_slice_pkg::*;
#(
  parameter int NW    = 9,
  parameter int NLANE = 8,
  parameter int ACC_W = 52
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [1:0]                size_sel,
  input  logic [1:0]                comb_sel,
  input  logic                      sgn_sel,
  input  logic                      acc_clear,
  input  logic [NW*NLANE-1:0]       a_bus,
  input  logic [NW*NLANE-1:0]       b_bus,
  output logic                      out_valid,
  output logic [2*NW*NLANE-1:0]     res_bus
);

  localparam int MLANE = NLANE / 2;

  cfg_t cfg_in, cfg_eff, cfg_q, s1_cfg;
  logic s1_v, s1_clr, busy;
  logic [NLANE-1:0][2*NW-1:0] s1_pn;
  logic [MLANE-1:0][4*NW-1:0] s1_pm;
  logic [8*NW-1:0]            s1_pw;

  always_comb begin
    cfg_in.size = size_e'(size_sel);
    cfg_in.comb = comb_e'(comb_sel);
    cfg_in.sgn  = sgn_sel;
  end

  assign busy = s1_v | out_valid;

  mac_slice_cfg u_cfg (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .busy     (busy),
    .cfg_in   (cfg_in),
    .cfg_eff  (cfg_eff),
    .cfg_q    (cfg_q)
  );

  mac_slice_mul #(.NW(NW), .NLANE(NLANE)) u_mul (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .cfg_in    (cfg_eff),
    .acc_clear (acc_clear),
    .a_bus     (a_bus),
    .b_bus     (b_bus),
    .v_q       (s1_v),
    .cfg_q     (s1_cfg),
    .clr_q     (s1_clr),
    .pn_q      (s1_pn),
    .pm_q      (s1_pm),
    .pw_q      (s1_pw)
  );

  mac_slice_comb #(.NW(NW), .NLANE(NLANE), .ACC_W(ACC_W)) u_comb (
    .clk       (clk),
    .rst       (rst),
    .v_in      (s1_v),
    .cfg       (s1_cfg),
    .clr       (s1_clr),
    .pn        (s1_pn),
    .pm        (s1_pm),
    .pw        (s1_pw),
    .out_valid (out_valid),
    .res_bus   (res_bus)
  );

endmodule

// File: rtl/mac_slice_chk.sv
module mac_slice_chk
  import mac_slice_pkg::*;
#(
  parameter int NW    = 9,
  parameter int NLANE = 8,
  parameter int ACC_W = 52
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  in_valid,
  input logic                  out_valid,
  input logic [2*NW*NLANE-1:0] res_bus,
  input logic                  s1_v,
  input cfg_t                  cfg_q,
  input cfg_t                  s1_cfg
);

  localparam int RES_W = 2 * NW * NLANE;
  localparam int SLOT  = RES_W / 2;
  localparam int WW    = 4 * NW;

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!out_valid && res_bus == '0));

  // R2
  latency_on_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ##1 out_valid);

  // R2
  latency_off_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ##1 !out_valid);

  // R11
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    s1_v |=> $stable(cfg_q));

  // R5
  wide_zext_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(s1_cfg.size[1]) && !$past(s1_cfg.sgn))
      |-> res_bus[RES_W-1:2*WW] == '0);

  // R8
  acc_zext_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(s1_cfg.comb) == CB_ACCUM && !$past(s1_cfg.size[1])
      && !$past(s1_cfg.sgn))
      |-> (res_bus[SLOT-1:ACC_W] == '0 && res_bus[RES_W-1:SLOT+ACC_W] == '0));

endmodule

bind mac_slice mac_slice_chk #(.NW(NW), .NLANE(NLANE), .ACC_W(ACC_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .res_bus   (res_bus),
  .s1_v      (s1_v),
  .cfg_q     (cfg_q),
  .s1_cfg    (s1_cfg)
);

// File: tb/sim_mac_slice.sv
`timescale 1ns/1ps
module sim_mac_slice;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [1:0]   size_sel = '0;
  logic [1:0]   comb_sel = '0;
  logic         sgn_sel = 1'b0;
  logic         acc_clear = 1'b0;
  logic [71:0]  a_bus = '0;
  logic [71:0]  b_bus = '0;
  logic         out_valid;
  logic [143:0] res_bus;

  always #5 clk = ~clk;

  mac_slice u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .size_sel(size_sel),
    .comb_sel(comb_sel), .sgn_sel(sgn_sel), .acc_clear(acc_clear),
    .a_bus(a_bus), .b_bus(b_bus), .out_valid(out_valid), .res_bus(res_bus)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Model state
  logic [51:0]  macc [2];
  logic [1:0]   m_sz, m_cb;
  logic         m_sg;
  bit           vh1 = 0, vh2 = 0;
  bit           p0_v = 0, p1_v = 0;
  logic [143:0] p0_res = '0, p1_res = '0;
  string        p0_req = "", p1_req = "";
  logic [31:0]  seed = 32'h1234_5678;

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  function automatic logic [71:0] rnd72();
    logic [31:0] x, y, z;
    x = rnd(); y = rnd(); z = rnd();
    return {x[7:0], y, z};
  endfunction

  function automatic logic [71:0] pat(input int k);
    case (k)
      0: return '0;
      1: return '1;
      2: return {8{9'h100}};
      3: return {8{9'h0FF}};
      4: return {4{18'h20000}};
      default: return {36'h0, 36'h8_0000_0000};
    endcase
  endfunction

  function automatic string rq(input logic [1:0] sz, cb, input logic sg, cl);
    string s;
    if (sz[1]) s = "R5";
    else if (cb == 2'd1) s = cl ? "R9" : "R8";
    else if (cb == 2'd2) s = "R6";
    else if (cb == 2'd3) s = "R7";
    else s = (sz == 2'd0) ? "R3" : "R4";
    if (sg) s = {s, " R10"};
    return s;
  endfunction

  // Expected result computed from the requirement text.
  function automatic logic [143:0] model(input logic [1:0] sz, cb, input logic sg, cl,
                                         input logic [71:0] a, b);
    logic [143:0] prods [8];
    logic [143:0] ea, eb, mk, r, s, e;
    int w, cnt, grp, nres, slot;
    w   = (sz == 2'd0) ? 9 : (sz == 2'd1) ? 18 : 36;
    cnt = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 4 : 1;
    mk  = (144'(1) << w) - 144'(1);
    for (int i = 0; i < 8; i++) begin
      prods[i] = '0;
      if (i < cnt) begin
        ea = (144'(a) >> (i * w)) & mk;
        eb = (144'(b) >> (i * w)) & mk;
        if (sg && ea[w-1]) ea = ea | ~mk;
        if (sg && eb[w-1]) eb = eb | ~mk;
        prods[i] = ea * eb;
      end
    end
    if (sz[1]) return prods[0];
    r = '0;
    if (cb == 2'd1) begin
      for (int j = 0; j < 2; j++) begin
        s = '0;
        for (int m = 0; m < cnt / 2; m++) s = s + prods[j*(cnt/2) + m];
        macc[j] = cl ? s[51:0] : macc[j] + s[51:0];
        e = 144'(macc[j]);
        if (sg && macc[j][51]) e = e | ~((144'(1) << 52) - 144'(1));
        r = r | ((e & ((144'(1) << 72) - 144'(1))) << (72 * j));
      end
      return r;
    end
    grp  = (cb == 2'd0) ? 1 : (cb == 2'd2) ? 2 : 4;
    nres = cnt / grp;
    slot = 144 / nres;
    for (int k = 0; k < nres; k++) begin
      s = '0;
      for (int g = 0; g < grp; g++) s = s + prods[k*grp + g];
      r = r | ((s & ((144'(1) << slot) - 144'(1))) << (k * slot));
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [143:0] act, exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [1:0] sz, cb, input logic sg, cl,
                      input logic [71:0] a, b, input string tag);
    @(negedge clk);
    // R2: valid two edges after the beat
    chk(out_valid == p1_v, "R2 out_valid", 144'(out_valid), 144'(p1_v));
    if (p1_v) chk(res_bus == p1_res, p1_req, res_bus, p1_res);
    p1_v = p0_v; p1_res = p0_res; p1_req = p0_req;
    in_valid = v; size_sel = sz; comb_sel = cb; sgn_sel = sg;
    acc_clear = cl; a_bus = a; b_bus = b;
    if (v) begin
      // R11: settings taken only when nothing is in flight
      if (!vh1 && !vh2) begin m_sz = sz; m_cb = cb; m_sg = sg; end
      p0_res = model(m_sz, m_cb, m_sg, cl, a, b);
      p0_req = {tag, " ", rq(m_sz, m_cb, m_sg, cl)};
    end
    p0_v = v; vh2 = vh1; vh1 = v;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, '0, '0, 0, 0, '0, '0, "idle");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R2 watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    macc[0] = '0; macc[1] = '0;
    m_sz = '0; m_cb = '0; m_sg = 0;
    repeat (4) @(negedge clk);
    // R1 during reset
    chk(!out_valid && res_bus == '0, "R1 in reset", res_bus, '0);
    rst = 1'b0;
    @(negedge clk);
    // R1 after release
    chk(!out_valid && res_bus == '0, "R1 after release", res_bus, '0);

    // Sweep every size, combine mode and signedness with corners and random data.
    for (int sz = 0; sz < 3; sz++)
      for (int cb = 0; cb < 4; cb++)
        for (int sg = 0; sg < 2; sg++) begin
          for (int p = 0; p < 6; p++)
            for (int q = 0; q < 6; q++)
              step(1, 2'(sz), 2'(cb), sg[0], (p == 0 && q == 0), pat(p), pat((p + q) % 6),
                   "corner");
          for (int n = 0; n < 40; n++) begin
            logic [31:0] r;
            r = rnd();
            step(1, 2'(sz), 2'(cb), sg[0], r[2:0] == 3'd0, rnd72(), rnd72(), "sweep");
          end
          idle(2);
        end

    // R11: random gaps, settings changing every cycle.
    for (int n = 0; n < 600; n++) begin
      logic [31:0] r;
      r = rnd();
      step(r[1:0] != 2'd0, r[3:2], r[5:4], r[6], r[9:7] == 3'd0, rnd72(), rnd72(),
           "R11 burst");
    end
    idle(2);

    // R8 wrap: medium unsigned accumulate with maximal products.
    step(1, 2'd1, 2'd1, 0, 1, '1, '1, "R8 wrap");
    for (int n = 0; n < 36000; n++) step(1, 2'd1, 2'd1, 0, 0, '1, '1, "R8 wrap");
    // R5: wide mode ignores combine, clear and high operand bits
    idle(2);
    for (int n = 0; n < 50; n++) begin
      logic [31:0] r;
      r = rnd();
      step(1, 2'd2 | 2'(r[0]), r[2:1], r[3], r[4], rnd72(), rnd72(), "R5 ignore");
    end
    idle(3);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule